// File: doc/BRIEF.md
# Programmable Asymmetric Clock Divider Channel

This block is one output channel of a clock distribution tree. It runs on a fast input clock and makes a logic-level output whose high time and low time are programmed on their own. Each phase lasts its field value plus one input cycles. A chip-wide active-low synchronisation strobe parks the counter at a chosen starting level. Releasing the strobe starts the output after a programmable extra delay, so several channels can be lined up in phase. A channel can opt out of that strobe.

Besides dividing, the channel has other ways to drive its output. It can pass its input through unchanged, or hold a static high level. A direct-routing switch, steered by a two-bit source select, can hand the output to the raw oscillator or to the external clock. A power-down bit parks the output low. The fast clock is `clk`. The oscillator and external clock levels arrive as data inputs, `osc_lvl` and `ext_lvl`. Every path is registered once before `clk_out`.

Top module: `clkdiv_channel`

## Requirements
- R1: In the divider path, every steady low phase of `clk_out` lasts `lo_cnt`+1 cycles of `clk`.
- R2: In the divider path, every steady high phase of `clk_out` lasts `hi_cnt`+1 cycles of `clk`.
- R3: With `byp` set and no higher-priority path active, the counter is frozen and `clk_out` equals `osc_lvl` from the previous cycle.
- R4: While `sync_n` is 0 and `ign_sync` is 0, in the divider path, `clk_out` shows `start_hi` from the previous cycle (1 = high).
- R5: After `sync_n` returns to 1, the first phase of `clk_out` holds the start level for `ph_off` + (`hi_cnt` or `lo_cnt`, as picked by `start_hi`) + 1 cycles. The phases then alternate per R1/R2.
- R6: With `ign_sync` set, `sync_n` has no effect, and the phase widths stay per R1/R2.
- R7: `force_hi`=1 forces `clk_out` high, but only when `ign_sync` is also 1. Otherwise `force_hi` has no effect on the divider output.
- R8: With `direct` set, `src_sel` picks the source. Code 2'b10 routes `osc_lvl`, and 2'b00 routes `ext_lvl` (one cycle late). Codes 2'b01 and 2'b11 keep the normal path. Direct routing outranks bypass and forcing.
- R9: `pwr_dn`=1 drives `clk_out` to 0 on the next cycle, over every other setting.
- R10: A change of `hi_cnt` or `lo_cnt` takes effect only at the next phase boundary. The phase in progress finishes with its old length.
- R11: While `rst` is high, `clk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast divider input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Chip-level synchronisation strobe, active low |
| osc_lvl | input | 1 | Level of the raw oscillator |
| ext_lvl | input | 1 | Level of the external clock |
| src_sel | input | 2 | Direct-route source: 10 oscillator, 00 external, others divider |
| lo_cnt | input | CNT_W | Low-phase length minus one |
| hi_cnt | input | CNT_W | High-phase length minus one |
| byp | input | 1 | Bypass the counter, pass the oscillator level |
| ign_sync | input | 1 | Ignore the synchronisation strobe |
| force_hi | input | 1 | Static high level (valid with ign_sync) |
| start_hi | input | 1 | First phase after release is high |
| ph_off | input | OFF_W | Extra delay of the first edge after release |
| pwr_dn | input | 1 | Park the output low |
| direct | input | 1 | Enable direct source routing |
| clk_out | output | 1 | Registered channel output |

## Verification
The sweep covers all 256 pairs of high and low counts, each with a random start level and phase offset. It measures the first three runs after a strobe release. A swapped high/low field, an off-by-one count, or an offset applied to the wrong phase each gives a distinct mismatch. Separate patterns check the other paths. A held strobe is tested with and without the ignore bit. Forcing is tested with and without that bit. Random oscillator and external levels run through bypass and through each source code, and power-down is tested over an active route. A field change in the middle of a phase shows whether reload happens only at boundaries.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    SRC_EXT = 2'b00,
    SRC_DIV = 2'b01,
    SRC_OSC = 2'b10,
    SRC_RSV = 2'b11
  } src_e;

  typedef enum logic [2:0] {
    OSEL_IDLE,
    OSEL_OSC,
    OSEL_EXT,
    OSEL_HIGH,
    OSEL_START,
    OSEL_DIV
  } osel_e;
endpackage

// File: rtl/clkdiv_route.sv
module clkdiv_route
  import clkdiv_pkg::*;
(
  input  logic  pwr_dn,
  input  logic  direct,
  input  logic  [1:0] src_sel,
  input  logic  byp,
  input  logic  ign_sync,
  input  logic  force_hi,
  input  logic  sync_n,
  output osel_e osel,
  output logic  ctr_run,
  output logic  ctr_hold
);
  src_e src;
  assign src = src_e'(src_sel);

  // Counter holds at its start state while the strobe is obeyed and low.
  assign ctr_hold = !ign_sync && !sync_n;
  // Counter idles in bypass and power-down.
  assign ctr_run  = !pwr_dn && !byp;

  // Priority: power-down, direct route, bypass, force, hold, divider.
  always_comb begin
    if (pwr_dn)                          osel = OSEL_IDLE;
    else if (direct && src == SRC_OSC)   osel = OSEL_OSC;
    else if (direct && src == SRC_EXT)   osel = OSEL_EXT;
    else if (byp)                        osel = OSEL_OSC;
    else if (ign_sync && force_hi)       osel = OSEL_HIGH;
    else if (ctr_hold)                   osel = OSEL_START;
    else                                 osel = OSEL_DIV;
  end
endmodule

// File: rtl/clkdiv_phase_ctr.sv
module clkdiv_phase_ctr #(
  parameter int CNT_W = 4,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold,
  input  logic             start_hi,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [OFF_W-1:0] ph_off,
  output logic             phase
);
  localparam int CW = ((OFF_W > CNT_W) ? OFF_W : CNT_W) + 1;

  logic [CW-1:0] remain;
  logic [CW-1:0] first_len;
  logic [CW-1:0] next_len;

  // Length minus one of the first phase after release, offset included.
  assign first_len = CW'(ph_off) + (start_hi ? CW'(hi_cnt) : CW'(lo_cnt));
  // Length minus one of the phase entered at the next boundary.
  assign next_len  = phase ? CW'(lo_cnt) : CW'(hi_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      remain <= '0;
    end else if (hold) begin
      phase  <= start_hi;
      remain <= first_len;
    end else if (run) begin
      if (remain == '0) begin
        phase  <= !phase;
        remain <= next_len;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkdiv_out_reg.sv
module clkdiv_out_reg
  import clkdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  osel_e osel,
  input  logic  osc_lvl,
  input  logic  ext_lvl,
  input  logic  start_hi,
  input  logic  phase,
  output logic  clk_out
);
  logic nxt;

  always_comb begin
    case (osel)
      OSEL_OSC:   nxt = osc_lvl;
      OSEL_EXT:   nxt = ext_lvl;
      OSEL_HIGH:  nxt = 1'b1;
      OSEL_START: nxt = start_hi;
      OSEL_DIV:   nxt = phase;
      default:    nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) clk_out <= 1'b0;
    else     clk_out <= nxt;
  end
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_n,
  input  logic             osc_lvl,
  input  logic             ext_lvl,
  input  logic [1:0]       src_sel,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic             byp,
  input  logic             ign_sync,
  input  logic             force_hi,
  input  logic             start_hi,
  input  logic [OFF_W-1:0] ph_off,
  input  logic             pwr_dn,
  input  logic             direct,
  output logic             clk_out
);
  osel_e osel;
  logic  ctr_run;
  logic  ctr_hold;
  logic  phase;

  clkdiv_route u_route (
    .pwr_dn   (pwr_dn),
    .direct   (direct),
    .src_sel  (src_sel),
    .byp      (byp),
    .ign_sync (ign_sync),
    .force_hi (force_hi),
    .sync_n   (sync_n),
    .osel     (osel),
    .ctr_run  (ctr_run),
    .ctr_hold (ctr_hold)
  );

  clkdiv_phase_ctr #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .run      (ctr_run),
    .hold     (ctr_hold),
    .start_hi (start_hi),
    .lo_cnt   (lo_cnt),
    .hi_cnt   (hi_cnt),
    .ph_off   (ph_off),
    .phase    (phase)
  );

  clkdiv_out_reg u_out (
    .clk      (clk),
    .rst      (rst),
    .osel     (osel),
    .osc_lvl  (osc_lvl),
    .ext_lvl  (ext_lvl),
    .start_hi (start_hi),
    .phase    (phase),
    .clk_out  (clk_out)
  );
endmodule

// File: rtl/clkdiv_channel_chk.sv
module clkdiv_channel_chk #(
  parameter int CNT_W = 4,
  parameter int OFF_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_n,
  input logic             osc_lvl,
  input logic             ext_lvl,
  input logic [1:0]       src_sel,
  input logic [CNT_W-1:0] lo_cnt,
  input logic [CNT_W-1:0] hi_cnt,
  input logic             byp,
  input logic             ign_sync,
  input logic             force_hi,
  input logic             start_hi,
  input logic [OFF_W-1:0] ph_off,
  input logic             pwr_dn,
  input logic             direct,
  input logic             clk_out
);
  logic routed;
  assign routed = direct && !src_sel[0];

  p_pd_idle_r9: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> !clk_out);

  p_route_osc_r8: assert property (@(posedge clk) disable iff (rst)
    (!pwr_dn && direct && src_sel == 2'b10) |=> clk_out == $past(osc_lvl));

  p_route_ext_r8: assert property (@(posedge clk) disable iff (rst)
    (!pwr_dn && direct && src_sel == 2'b00) |=> clk_out == $past(ext_lvl));

  p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (!pwr_dn && !routed && byp) |=> clk_out == $past(osc_lvl));

  p_force_r7: assert property (@(posedge clk) disable iff (rst)
    (!pwr_dn && !routed && !byp && ign_sync && force_hi) |=> clk_out);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!pwr_dn && !routed && !byp && !ign_sync && !sync_n)
      |=> clk_out == $past(start_hi));
endmodule

bind clkdiv_channel clkdiv_channel_chk #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .sync_n(sync_n), .osc_lvl(osc_lvl), .ext_lvl(ext_lvl),
  .src_sel(src_sel), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .byp(byp),
  .ign_sync(ign_sync), .force_hi(force_hi), .start_hi(start_hi),
  .ph_off(ph_off), .pwr_dn(pwr_dn), .direct(direct), .clk_out(clk_out)
);

// File: tb/clkdiv_channel_bench.sv
module clkdiv_channel_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_n = 1'b1;
  logic       osc_lvl = 1'b0;
  logic       ext_lvl = 1'b0;
  logic [1:0] src_sel = 2'b01;
  logic [3:0] lo_cnt = 4'd3;
  logic [3:0] hi_cnt = 4'd3;
  logic       byp = 1'b0;
  logic       ign_sync = 1'b0;
  logic       force_hi = 1'b0;
  logic       start_hi = 1'b0;
  logic [3:0] ph_off = 4'd0;
  logic       pwr_dn = 1'b0;
  logic       direct = 1'b0;
  logic       clk_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;
  logic cur;

  always #2 clk = ~clk;

  clkdiv_channel u_clkdiv_channel (
    .clk(clk), .rst(rst), .sync_n(sync_n), .osc_lvl(osc_lvl), .ext_lvl(ext_lvl),
    .src_sel(src_sel), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .byp(byp),
    .ign_sync(ign_sync), .force_hi(force_hi), .start_hi(start_hi),
    .ph_off(ph_off), .pwr_dn(pwr_dn), .direct(direct), .clk_out(clk_out)
  );

  function automatic int phase_len(input logic [3:0] field);
    return int'(field) + 1;
  endfunction

  function automatic int first_len(input logic [3:0] off, input logic st,
                                   input logic [3:0] lo, input logic [3:0] hi);
    return int'(off) + (st ? phase_len(hi) : phase_len(lo));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Length of the run that contains the current sample; on return, cur holds the next level.
  task automatic next_run(output int n, output logic lvl);
    lvl = cur;
    n = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (clk_out !== lvl) begin
        cur = clk_out;
        return;
      end
      n++;
    end
  endtask

  task automatic sync_release(input int hold_cycles);
    sync_n = 1'b0;
    repeat (hold_cycles) @(negedge clk);
    sync_n = 1'b1;
    @(negedge clk);
    cur = clk_out;
  endtask

  task automatic clear_modes;
    byp = 0; ign_sync = 0; force_hi = 0; pwr_dn = 0; direct = 0;
    src_sel = 2'b01; ph_off = 0; start_hi = 0; sync_n = 1;
  endtask

  initial begin
    int   n;
    logic lvl;
    int   bad;
    logic v;
    void'($urandom(32'd4711));

    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 reset low", int'(clk_out), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4: held strobe shows the start level, both polarities
    start_hi = 1; sync_n = 0;
    repeat (3) @(negedge clk);
    check("R4 hold start high", int'(clk_out), 1);
    start_hi = 0;
    repeat (2) @(negedge clk);
    check("R4 hold start low", int'(clk_out), 0);
    sync_n = 1;

    // R1 R2 R5: sweep of all high/low pairs with random start and offset
    for (int l = 0; l < 16; l++) begin
      for (int h = 0; h < 16; h++) begin
        lo_cnt = 4'(l); hi_cnt = 4'(h);
        start_hi = 1'($urandom());
        ph_off = 4'($urandom());
        sync_release(2);
        next_run(n, lvl);
        check("R5 first run level", int'(lvl), int'(start_hi));
        check("R5 first run length", n, first_len(ph_off, start_hi, lo_cnt, hi_cnt));
        next_run(n, lvl);
        check(lvl ? "R2 high width" : "R1 low width", n,
              lvl ? phase_len(hi_cnt) : phase_len(lo_cnt));
        next_run(n, lvl);
        check(lvl ? "R2 high width" : "R1 low width", n,
              lvl ? phase_len(hi_cnt) : phase_len(lo_cnt));
      end
    end
    clear_modes();

    // R6: strobe held low while ignored leaves widths intact
    lo_cnt = 4'd2; hi_cnt = 4'd5; ign_sync = 1; sync_n = 0;
    @(negedge clk); cur = clk_out;
    next_run(n, lvl);
    for (int k = 0; k < 2; k++) begin
      next_run(n, lvl);
      check("R6 ignored strobe width", n, lvl ? 6 : 3);
    end
    sync_n = 1;

    // R7: force high honoured with ign_sync set
    force_hi = 1;
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (clk_out !== 1'b1) bad++;
    end
    check("R7 forced high", bad, 0);

    // R7: force high without ign_sync has no effect on the divider
    ign_sync = 0;
    sync_release(2);
    next_run(n, lvl);
    check("R7 force ignored first low run", n, 3);
    next_run(n, lvl);
    check("R7 force ignored high run", n, 6);
    clear_modes();

    // R3: bypass passes the oscillator level
    byp = 1;
    bad = 0;
    for (int k = 0; k < 24; k++) begin
      v = 1'($urandom());
      osc_lvl = v;
      @(negedge clk);
      if (clk_out !== v) bad++;
    end
    check("R3 bypass follows osc", bad, 0);

    // R8: direct route to oscillator beats force
    byp = 0; direct = 1; src_sel = 2'b10; ign_sync = 1; force_hi = 1;
    bad = 0;
    for (int k = 0; k < 24; k++) begin
      v = 1'($urandom());
      osc_lvl = v;
      @(negedge clk);
      if (clk_out !== v) bad++;
    end
    check("R8 route osc", bad, 0);

    // R8: direct route to external clock beats bypass
    src_sel = 2'b00; byp = 1; ign_sync = 0; force_hi = 0;
    bad = 0;
    for (int k = 0; k < 24; k++) begin
      v = 1'($urandom());
      ext_lvl = v;
      osc_lvl = ~v;
      @(negedge clk);
      if (clk_out !== v) bad++;
    end
    check("R8 route ext", bad, 0);

    // R8: codes 01 and 11 keep the divider path
    byp = 0; lo_cnt = 4'd4; hi_cnt = 4'd1;
    for (int c = 1; c < 4; c += 2) begin
      src_sel = 2'(c);
      sync_release(2);
      next_run(n, lvl);
      check("R8 divider kept first low", n, 5);
      next_run(n, lvl);
      check("R8 divider kept high", n, 2);
    end

    // R9: power-down overrides an active route
    src_sel = 2'b10; osc_lvl = 1; pwr_dn = 1;
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (clk_out !== 1'b0) bad++;
    end
    check("R9 power-down low", bad, 0);
    clear_modes();

    // R10: change in mid-phase applies at the next boundary
    lo_cnt = 4'd7; hi_cnt = 4'd7;
    sync_release(2);
    next_run(n, lvl);
    check("R10 low before change", n, 8);
    hi_cnt = 4'd1;
    next_run(n, lvl);
    check("R10 high phase keeps old length", n, 8);
    next_run(n, lvl);
    check("R10 low unchanged", n, 8);
    next_run(n, lvl);
    check("R10 new high length", n, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule